// File: doc/BRIEF.md
# Region write-protected RAM

A synchronous byte-wide RAM for a simple CPU bus. Its storage is cut into equal regions, and each region owns one bit of a write-mask register. A bus write that lands in a region whose mask bit is set is dropped without any error. This lets a scheduler lock the memory that belongs to itself and to other tasks while one task runs. The mask register takes new values only while the CPU's interrupt flag is high, so code outside interrupt context cannot unlock anything.

The RAM sits at bus address 0 and is either 1 KB (16 regions) or 4 KB (32 regions). The mask register can be read back at its own small address window. Reads are registered, so data appears one cycle after the address. The read bus is zero whenever neither the RAM nor the mask window is addressed, so it can be OR-merged with other readers. With the protection parameter left at its default, the block behaves as plain RAM.

Top module: `prot_ram`

## Requirements
- R1: With MEM_BYTES=1024 there are 16 regions of 64 bytes. Address bits [9:6] pick mask bit k, which covers addresses k*64 to k*64+63.
- R2: With MEM_BYTES=4096 there are 32 regions of 128 bytes. Address bits [11:7] pick mask bit k, which covers addresses k*128 to k*128+127.
- R3: When PROTECT=1 and the mask bit of a region is 1, a write into that region leaves the stored byte unchanged. Writes to regions whose mask bit is 0 succeed.
- R4: A write to the mask window changes the mask only when irq_flag is 1 in the same cycle. With irq_flag at 0 the mask reads back unchanged.
- R5: Reset (rst high at a rising edge) clears every mask bit to 0, so every region accepts writes afterwards.
- R6: Mask byte i sits at MASK_BASE+i and holds mask bits [8i+7:8i]. There are 2 such bytes for 16 regions and 4 for 32 regions. Addresses past the last byte are not part of the window.
- R7: A read of RAM address a presents the stored byte on rd_data one cycle after the address is applied. Reads are never blocked by the mask.
- R8: rd_data is 0 in the cycle after an address that hits neither the RAM nor the mask window.
- R9: With PROTECT=0 every RAM write succeeds whatever has been written to the mask window, and the mask window reads 0.
- R10: When a read and a write hit the same RAM address in the same cycle, rd_data returns the byte that was stored before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 16 | Bus byte address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| irq_flag | input | 1 | Current level of the CPU interrupt flag |
| rd_data | output | 8 | Registered read data, zero when not addressed |

## Verification
The bench builds three copies that share one bus: 1 KB with protection on, 4 KB with protection on, and 1 KB with protection off. A single write stream therefore shows the two region granularities side by side, since one mask bit locks a 64-byte span in one copy and a 128-byte span in the other. The same stream shows the unprotected copy ignoring the mask. The high mask bytes that exist only in the 4 KB copy, and addresses above 1 KB, test the window limits and the zero read bus.

// File: rtl/prot_ram_pkg.sv
package prot_ram_pkg;
  localparam int BUS_AW = 16;
  localparam int DW     = 8;

  // number of protection regions for a given RAM size
  function automatic int region_count(input int mem_bytes);
    return (mem_bytes > 1024) ? 32 : 16;
  endfunction

  // bytes needed to hold one mask bit per region
  function automatic int mask_bytes(input int mem_bytes);
    return region_count(mem_bytes) / 8;
  endfunction
endpackage

// File: rtl/prot_ram_decode.sv
module prot_ram_decode #(
  parameter int          RAM_AW    = 10,
  parameter int          RB        = 4,
  parameter int          MB_W      = 1,
  parameter logic [15:0] MASK_BASE = 16'hF000
) (
  input  logic [15:0]       addr,
  output logic              ram_sel,
  output logic              mask_sel,
  output logic [RAM_AW-1:0] ram_addr,
  output logic [RB-1:0]     region,
  output logic [MB_W-1:0]   mask_byte
);
  localparam logic [15-MB_W:0] MB_HI = MASK_BASE[15:MB_W];

  always_comb begin
    ram_sel   = (addr[15:RAM_AW] == '0);
    mask_sel  = (addr[15:MB_W] == MB_HI);
    ram_addr  = addr[RAM_AW-1:0];
    region    = addr[RAM_AW-1 -: RB];
    mask_byte = addr[MB_W-1:0];
  end
endmodule

// File: rtl/prot_ram_mask.sv
module prot_ram_mask #(
  parameter int MASK_W  = 16,
  parameter int MB_W    = 1,
  parameter bit PROTECT = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              mask_sel,
  input  logic              irq_flag,
  input  logic [MB_W-1:0]   mask_byte,
  input  logic [7:0]        wr_data,
  output logic [MASK_W-1:0] mask_q,
  output logic [7:0]        mask_rd,
  output logic              mask_wr_ok
);
  generate
    if (PROTECT) begin : g_mask
      assign mask_wr_ok = wr_en & mask_sel & irq_flag;
      always_ff @(posedge clk) begin
        if (rst)             mask_q <= '0;
        else if (mask_wr_ok) mask_q[int'(mask_byte)*8 +: 8] <= wr_data;
      end
    end else begin : g_plain
      logic unused_in;
      assign unused_in  = ^{clk, rst, wr_en, mask_sel, irq_flag, wr_data};
      assign mask_wr_ok = 1'b0;
      assign mask_q     = '0;
    end
  endgenerate

  assign mask_rd = mask_q[int'(mask_byte)*8 +: 8];
endmodule

// File: rtl/prot_ram_array.sv
module prot_ram_array #(
  parameter int MEM_BYTES = 1024,
  parameter int RAM_AW    = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [RAM_AW-1:0] ram_addr,
  input  logic [7:0]        wr_data,
  input  logic              ram_sel,
  input  logic              mask_sel,
  input  logic [7:0]        mask_rd,
  output logic [7:0]        rd_data
);
  logic [7:0] mem [MEM_BYTES];

  always_ff @(posedge clk) begin
    if (we) mem[ram_addr] <= wr_data;
  end

  // read-first: the registered read sees the byte stored before this edge
  always_ff @(posedge clk) begin
    if (rst)           rd_data <= '0;
    else if (ram_sel)  rd_data <= mem[ram_addr];
    else if (mask_sel) rd_data <= mask_rd;
    else               rd_data <= '0;
  end
endmodule

// File: rtl/prot_ram.sv
module prot_ram #(
  parameter int          MEM_BYTES = 1024,
  parameter bit          PROTECT   = 1'b0,
  parameter logic [15:0] MASK_BASE = 16'hF000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [15:0] addr,
  input  logic        wr_en,
  input  logic [7:0]  wr_data,
  input  logic        irq_flag,
  output logic [7:0]  rd_data
);
  import prot_ram_pkg::*;

  localparam int REGIONS = region_count(MEM_BYTES);
  localparam int RB      = $clog2(REGIONS);
  localparam int MBYTES  = mask_bytes(MEM_BYTES);
  localparam int MB_W    = $clog2(MBYTES);
  localparam int RAM_AW  = $clog2(MEM_BYTES);

  logic              ram_sel, mask_sel;
  logic [RAM_AW-1:0] ram_addr;
  logic [RB-1:0]     region;
  logic [MB_W-1:0]   mask_byte;
  logic [REGIONS-1:0] mask_q;
  logic [7:0]        mask_rd;
  logic              mask_wr_ok;

  // named events for the checker
  logic region_locked, ram_wr_req, ram_wr_ok, ram_wr_blocked;

  prot_ram_decode #(.RAM_AW(RAM_AW), .RB(RB), .MB_W(MB_W), .MASK_BASE(MASK_BASE)) u_dec (
    .addr(addr), .ram_sel(ram_sel), .mask_sel(mask_sel),
    .ram_addr(ram_addr), .region(region), .mask_byte(mask_byte)
  );

  prot_ram_mask #(.MASK_W(REGIONS), .MB_W(MB_W), .PROTECT(PROTECT)) u_mask (
    .clk(clk), .rst(rst), .wr_en(wr_en), .mask_sel(mask_sel),
    .irq_flag(irq_flag), .mask_byte(mask_byte), .wr_data(wr_data),
    .mask_q(mask_q), .mask_rd(mask_rd), .mask_wr_ok(mask_wr_ok)
  );

  assign region_locked  = PROTECT & mask_q[region];
  assign ram_wr_req     = wr_en & ram_sel;
  assign ram_wr_ok      = ram_wr_req & ~region_locked;
  assign ram_wr_blocked = ram_wr_req & region_locked;

  prot_ram_array #(.MEM_BYTES(MEM_BYTES), .RAM_AW(RAM_AW)) u_arr (
    .clk(clk), .rst(rst), .we(ram_wr_ok), .ram_addr(ram_addr),
    .wr_data(wr_data), .ram_sel(ram_sel), .mask_sel(mask_sel),
    .mask_rd(mask_rd), .rd_data(rd_data)
  );
endmodule

// File: rtl/prot_ram_chk.sv
module prot_ram_chk #(
  parameter int MASK_W  = 16,
  parameter int RB      = 4,
  parameter bit PROTECT = 1'b0
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              irq_flag,
  input logic              ram_sel,
  input logic              mask_sel,
  input logic [RB-1:0]     region,
  input logic [MASK_W-1:0] mask_q,
  input logic              ram_wr_req,
  input logic              ram_wr_ok,
  input logic              ram_wr_blocked,
  input logic [7:0]        rd_data
);
  // R4
  mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && mask_sel && !irq_flag) |=> $stable(mask_q));

  // R5
  mask_reset_chk: assert property (@(posedge clk)
    rst |=> (mask_q == '0));

  // R3
  lock_block_chk: assert property (@(posedge clk) disable iff (rst)
    (PROTECT && ram_wr_req && mask_q[region]) |-> (!ram_wr_ok && ram_wr_blocked));

  // R9
  plain_write_chk: assert property (@(posedge clk) disable iff (rst)
    (!PROTECT && ram_wr_req) |-> ram_wr_ok);

  // R8
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (!ram_sel && !mask_sel) |=> (rd_data == 8'h00));

  // R6
  select_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ram_sel, mask_sel}));
endmodule

bind prot_ram prot_ram_chk #(.MASK_W(REGIONS), .RB(RB), .PROTECT(PROTECT)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .irq_flag(irq_flag),
  .ram_sel(ram_sel), .mask_sel(mask_sel), .region(region), .mask_q(mask_q),
  .ram_wr_req(ram_wr_req), .ram_wr_ok(ram_wr_ok),
  .ram_wr_blocked(ram_wr_blocked), .rd_data(rd_data)
);

// File: tb/sim_prot_ram.sv
module sim_prot_ram;
  localparam int          CLK_PERIOD = 10;
  localparam logic [15:0] MB         = 16'hF000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [15:0] addr = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       irq_flag = 1'b0;
  logic [7:0] rd0, rd1, rd2;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // 1 KB protected
  prot_ram #(.MEM_BYTES(1024), .PROTECT(1'b1), .MASK_BASE(MB)) u0 (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .irq_flag(irq_flag), .rd_data(rd0));
  // 4 KB protected
  prot_ram #(.MEM_BYTES(4096), .PROTECT(1'b1), .MASK_BASE(MB)) u1 (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .irq_flag(irq_flag), .rd_data(rd1));
  // 1 KB unprotected
  prot_ram #(.MEM_BYTES(1024), .PROTECT(1'b0), .MASK_BASE(MB)) u2 (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .irq_flag(irq_flag), .rd_data(rd2));

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d, input logic irq);
    @(negedge clk);
    addr = a; wr_en = 1'b1; wr_data = d; irq_flag = irq;
    @(negedge clk);
    wr_en = 1'b0; irq_flag = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a);
    @(negedge clk);
    addr = a; wr_en = 1'b0;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    rd(MB);     chk("R5", "u0 mask byte0", rd0, 8'h00); chk("R5", "u1 mask byte0", rd1, 8'h00);
    rd(MB + 1); chk("R5", "u0 mask byte1", rd0, 8'h00);
    rd(MB + 3); chk("R5", "u1 mask byte3", rd1, 8'h00);
    rd(16'h8000);
    chk("R8", "u0 idle", rd0, 8'h00); chk("R8", "u1 idle", rd1, 8'h00); chk("R8", "u2 idle", rd2, 8'h00);
  endtask

  task automatic t_plain;
    wr(16'h0005, 8'hA5, 1'b0);
    rd(16'h0005);
    chk("R7", "u0 rd 005", rd0, 8'hA5); chk("R7", "u1 rd 005", rd1, 8'hA5); chk("R7", "u2 rd 005", rd2, 8'hA5);
    wr(16'h0080, 8'h22, 1'b0); wr(16'h00BF, 8'h21, 1'b0);
    wr(16'h00C0, 8'h33, 1'b0); wr(16'h0100, 8'h44, 1'b0);
    wr(16'h007F, 8'h55, 1'b0);
    wr(16'h03FF, 8'h3C, 1'b0); wr(16'h0FFF, 8'h3C, 1'b0);
    rd(16'h0FFF); chk("R5", "u1 rd FFF", rd1, 8'h3C);
    rd(16'h8000); chk("R8", "u1 idle after read", rd1, 8'h00);
  endtask

  task automatic t_nopriv;
    wr(MB, 8'hFF, 1'b0);
    rd(MB); chk("R4", "u0 mask unprivileged", rd0, 8'h00); chk("R4", "u1 mask unprivileged", rd1, 8'h00);
    wr(16'h0080, 8'h23, 1'b0);
    rd(16'h0080); chk("R4", "u0 region2 still open", rd0, 8'h23);
    wr(16'h0080, 8'h22, 1'b0);
  endtask

  task automatic t_lock_low;
    wr(MB, 8'h04, 1'b1);
    rd(MB);
    chk("R6", "u0 mask byte0", rd0, 8'h04); chk("R6", "u1 mask byte0", rd1, 8'h04);
    chk("R9", "u2 mask reads 0", rd2, 8'h00);
    wr(16'h0080, 8'h99, 1'b0); wr(16'h00BF, 8'h9A, 1'b0);
    wr(16'h00C0, 8'h98, 1'b0); wr(16'h0100, 8'h97, 1'b0);
    wr(16'h007F, 8'h96, 1'b0);
    rd(16'h0080); chk("R3", "u0 080 blocked", rd0, 8'h22); chk("R2", "u1 080 region1", rd1, 8'h99);
    chk("R9", "u2 080 written", rd2, 8'h99);
    rd(16'h00BF); chk("R1", "u0 0BF last byte blocked", rd0, 8'h21); chk("R2", "u1 0BF", rd1, 8'h9A);
    rd(16'h00C0); chk("R1", "u0 0C0 region3 open", rd0, 8'h98);
    rd(16'h007F); chk("R1", "u0 07F region1 open", rd0, 8'h96);
    rd(16'h0100); chk("R1", "u0 100 region4", rd0, 8'h97); chk("R2", "u1 100 blocked", rd1, 8'h44);
    chk("R9", "u2 100 written", rd2, 8'h97);
  endtask

  task automatic t_lock_high;
    wr(MB + 1, 8'h80, 1'b1); wr(MB + 3, 8'h80, 1'b1);
    rd(MB + 1); chk("R6", "u0 mask byte1", rd0, 8'h80); chk("R6", "u1 mask byte1", rd1, 8'h80);
    rd(MB + 3); chk("R6", "u0 beyond window", rd0, 8'h00); chk("R6", "u1 mask byte3", rd1, 8'h80);
    rd(MB + 2); chk("R6", "u1 mask byte2", rd1, 8'h00);
    wr(16'h03FF, 8'h5A, 1'b0); wr(16'h0FFF, 8'h5A, 1'b0);
    rd(16'h03FF); chk("R1", "u0 3FF region15 blocked", rd0, 8'h3C); chk("R2", "u1 3FF region7", rd1, 8'h5A);
    chk("R9", "u2 3FF", rd2, 8'h5A);
    rd(16'h0FFF); chk("R2", "u1 FFF region31 blocked", rd1, 8'h3C); chk("R8", "u0 above RAM", rd0, 8'h00);
  endtask

  task automatic t_rdw;
    wr(16'h0010, 8'h01, 1'b0);
    @(negedge clk);
    addr = 16'h0010; wr_en = 1'b1; wr_data = 8'h02;
    @(posedge clk); #1;
    chk("R10", "u0 old data", rd0, 8'h01); chk("R10", "u1 old data", rd1, 8'h01);
    @(negedge clk); wr_en = 1'b0;
    rd(16'h0010); chk("R10", "u0 new data", rd0, 8'h02);
  endtask

  task automatic t_rereset;
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    rd(MB);     chk("R5", "u0 mask after reset", rd0, 8'h00);
    rd(MB + 3); chk("R5", "u1 mask3 after reset", rd1, 8'h00);
    wr(16'h0080, 8'h77, 1'b0); wr(16'h0FFF, 8'h78, 1'b0);
    rd(16'h0080); chk("R5", "u0 080 open after reset", rd0, 8'h77);
    rd(16'h0FFF); chk("R5", "u1 FFF open after reset", rd1, 8'h78);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_plain();
    t_nopriv();
    t_lock_low();
    t_lock_high();
    t_rdw();
    t_rereset();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule